// File: doc/BRIEF.md
# Raster-Synchronised DRAM Refresh Sequencer

This block belongs to a video display controller that also keeps the system DRAM refreshed. It watches the horizontal pixel position and the scanline number. Once per line it opens a refresh window, and while that window is open it steps an 8-bit refresh row address. A separate single-clock request tells the CPU clock generator to slow to single speed around the refresh slots. The window and the single-clock request are two independent set/clear latches. Each is set and cleared by compares at fixed horizontal positions. The single-clock request ends at its own position, so the window can outlive it. This happens when the horizontal counter is moved past the window's clear position. In that case the row counter keeps counting while the CPU is already back at double speed.

The row counter returns to zero at one fixed horizontal position. This happens on scanline zero, and also on any line where the halt bit is set or the window is still open at that point. When the controller is halted, refresh runs on every clock-enable strobe and single-clock mode is forced. A fault-injection input can stop the window latch from setting, so that missing refresh can be provoked on purpose.

All state changes happen only on clock-enable strobes. The row address and the refresh-active output are registered.

Top module: `raster_refresh_seq`

## Requirements
- R1: A synchronous active-high `rst` sets `row_addr` to 0, and `ref_active` and `single_clk_req` to 0.
- R2: A strobe with `hpos` = WIN_SET_POS (default 296) opens the window. Counting begins on the next strobe. The window closes on the strobe at WIN_CLR_POS (default 336), and that strobe still counts. A normal line therefore gives 40 increments.
- R3: `single_clk_req` rises after the strobe at WIN_SET_POS and falls after the strobe at SCLK_END_POS (default 344). This is independent of the window: a window left open keeps counting with `single_clk_req` low.
- R4: The row counter is 8 bits wide and wraps from 255 to 0.
- R5: A strobe at RST_POS (default 431) with `line_num` = 0 sets `row_addr` to 0 and `ref_active` to 0. This reset takes priority over an increment in the same strobe.
- R6: On a nonzero line, the RST_POS strobe resets the counter only if `halt` is set or the window is still open. Otherwise `row_addr` holds.
- R7: While `halt` = 1, `single_clk_req` is 1 in the same cycle. Every strobe other than a reset strobe then increments the row and drives `ref_active` to 1.
- R8: While `ce` = 0, `row_addr`, `ref_active` and both latches hold their values, whatever `hpos` shows.
- R9: While `inhibit_set` = 1, the window cannot open. No row increments and no `ref_active` pulses occur on a line. `single_clk_req` still follows R3.
- R10: `ref_active` is 1 after a strobe exactly when that strobe incremented the row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock-enable strobe; all state advances only when high |
| hpos | input | 9 | Horizontal pixel position |
| line_num | input | 9 | Current scanline number |
| halt | input | 1 | Controller halt: forces refresh on every strobe and single-clock mode |
| inhibit_set | input | 1 | Fault injection: blocks the refresh window from opening |
| row_addr | output | 8 | Refresh row address (registered) |
| ref_active | output | 1 | High after a strobe that performed a refresh step (registered) |
| single_clk_req | output | 1 | Request for the CPU to run at single clock speed |

## Verification
Two functions can fall in the same strobe: the row counter's reset at RST_POS and its increment. The increment is live whenever the window is still open or the halt bit is set. The bench provokes the collision in two ways. It jumps the horizontal position past the window's clear compare, so the window stays open into RST_POS on a nonzero line. It also runs with the halt bit set at RST_POS. In both cases it expects the row to read zero with `ref_active` low after that strobe, and an increment to one on the strobe after it.

// File: rtl/ref_seq_pkg.sv
package ref_seq_pkg;

   // Decoded horizontal-position events for one strobe
   typedef struct packed {
      logic win_set;
      logic win_clr;
      logic sclk_end;
      logic row_rst;
   } pos_hits_t;

endpackage

// File: rtl/ref_pos_decode.sv
module ref_pos_decode
   import ref_seq_pkg::*;
#(
   parameter int HPOS_W       = 9,
   parameter int WIN_SET_POS  = 296,
   parameter int WIN_CLR_POS  = 336,
   parameter int SCLK_END_POS = 344,
   parameter int RST_POS      = 431
) (
   input  logic [HPOS_W-1:0] hpos,
   output pos_hits_t         hits
);

   localparam int NPOS = 4;
   localparam int POS_LIMIT = 1 << HPOS_W;
   localparam int POS_TAB [NPOS] = '{WIN_SET_POS, WIN_CLR_POS, SCLK_END_POS, RST_POS};

   initial begin
      assert (HPOS_W >= 2 && HPOS_W <= 16) else $error("HPOS_W out of range");
      assert (WIN_SET_POS < POS_LIMIT && WIN_CLR_POS < POS_LIMIT &&
              SCLK_END_POS < POS_LIMIT && RST_POS < POS_LIMIT)
         else $error("compare position exceeds hpos width");
      assert (WIN_SET_POS != WIN_CLR_POS) else $error("window set equals clear");
      assert (WIN_SET_POS != SCLK_END_POS) else $error("single-clock set equals end");
   end

   logic [NPOS-1:0] match;

   for (genvar i = 0; i < NPOS; i++) begin : g_cmp
      assign match[i] = (hpos == HPOS_W'(POS_TAB[i]));
   end

   assign hits.win_set  = match[0];
   assign hits.win_clr  = match[1];
   assign hits.sclk_end = match[2];
   assign hits.row_rst  = match[3];

endmodule

// File: rtl/ref_gate_latch.sv
module ref_gate_latch #(
   parameter bit SET_WINS = 1'b1   // priority when set and clear coincide
) (
   input  logic clk,
   input  logic rst,
   input  logic ce,
   input  logic set_i,
   input  logic clr_i,
   input  logic block_i,
   output logic q
);

   logic set_ok;
   logic q_next;

   assign set_ok = set_i & ~block_i;

   if (SET_WINS) begin : g_set_pri
      always_comb begin
         if (set_ok)     q_next = 1'b1;
         else if (clr_i) q_next = 1'b0;
         else            q_next = q;
      end
   end else begin : g_clr_pri
      always_comb begin
         if (clr_i)       q_next = 1'b0;
         else if (set_ok) q_next = 1'b1;
         else             q_next = q;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)     q <= 1'b0;
      else if (ce) q <= q_next;
   end

   assert_latch_set_R2: assert property (@(posedge clk) disable iff (rst)
      ce && set_i && !block_i && !clr_i |=> q);
   assert_latch_clr_R3: assert property (@(posedge clk) disable iff (rst)
      ce && clr_i && !set_i |=> !q);
   assert_latch_block_R9: assert property (@(posedge clk) disable iff (rst)
      ce && block_i && !q |=> !q);
   assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !ce |=> $stable(q));

endmodule

// File: rtl/ref_row_ctr.sv
module ref_row_ctr #(
   parameter int ROW_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ce,
   input  logic             adv_i,
   input  logic             clr_i,
   output logic [ROW_W-1:0] row_q,
   output logic             active_q
);

   localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);

   initial begin
      assert (ROW_W >= 1 && ROW_W <= 16) else $error("ROW_W out of range");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         row_q    <= '0;
         active_q <= 1'b0;
      end else if (ce) begin
         if (clr_i) begin
            row_q    <= '0;
            active_q <= 1'b0;
         end else begin
            if (adv_i) row_q <= row_q + ROW_ONE;
            active_q <= adv_i;
         end
      end
   end

   assert_row_reset_R5: assert property (@(posedge clk) disable iff (rst)
      ce && clr_i |=> row_q == '0 && !active_q);
   assert_row_step_R4: assert property (@(posedge clk) disable iff (rst)
      ce && adv_i && !clr_i |=> row_q == ROW_W'($past(row_q) + ROW_ONE));
   assert_active_match_R10: assert property (@(posedge clk) disable iff (rst)
      ce && !clr_i && !adv_i |=> !active_q && $stable(row_q));
   assert_row_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !ce |=> $stable(row_q) && $stable(active_q));

endmodule

// File: rtl/raster_refresh_seq.sv
module raster_refresh_seq
   import ref_seq_pkg::*;
#(
   parameter int HPOS_W       = 9,
   parameter int LINE_W       = 9,
   parameter int ROW_W        = 8,
   parameter int WIN_SET_POS  = 296,
   parameter int WIN_CLR_POS  = 336,
   parameter int SCLK_END_POS = 344,
   parameter int RST_POS      = 431
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce,
   input  logic [HPOS_W-1:0] hpos,
   input  logic [LINE_W-1:0] line_num,
   input  logic              halt,
   input  logic              inhibit_set,
   output logic [ROW_W-1:0]  row_addr,
   output logic              ref_active,
   output logic              single_clk_req
);

   initial begin
      assert (LINE_W >= 1 && LINE_W <= 16) else $error("LINE_W out of range");
   end

   pos_hits_t hits;
   logic      win_q;
   logic      sclk_q;
   logic      row_clr;
   logic      row_adv;

   ref_pos_decode #(
      .HPOS_W      (HPOS_W),
      .WIN_SET_POS (WIN_SET_POS),
      .WIN_CLR_POS (WIN_CLR_POS),
      .SCLK_END_POS(SCLK_END_POS),
      .RST_POS     (RST_POS)
   ) u_decode (
      .hpos(hpos),
      .hits(hits)
   );

   // Refresh window: may be blocked by fault injection
   ref_gate_latch #(.SET_WINS(1'b1)) u_win (
      .clk    (clk),
      .rst    (rst),
      .ce     (ce),
      .set_i  (hits.win_set),
      .clr_i  (hits.win_clr),
      .block_i(inhibit_set),
      .q      (win_q)
   );

   // Single-clock request: own end compare, never blocked
   ref_gate_latch #(.SET_WINS(1'b1)) u_sclk (
      .clk    (clk),
      .rst    (rst),
      .ce     (ce),
      .set_i  (hits.win_set),
      .clr_i  (hits.sclk_end),
      .block_i(1'b0),
      .q      (sclk_q)
   );

   assign row_clr = hits.row_rst & ((line_num == '0) | halt | win_q);
   assign row_adv = win_q | halt;

   ref_row_ctr #(.ROW_W(ROW_W)) u_row (
      .clk     (clk),
      .rst     (rst),
      .ce      (ce),
      .adv_i   (row_adv),
      .clr_i   (row_clr),
      .row_q   (row_addr),
      .active_q(ref_active)
   );

   assign single_clk_req = sclk_q | halt;

   assert_halt_refresh_R7: assert property (@(posedge clk) disable iff (rst)
      ce && halt && hpos != HPOS_W'(RST_POS) |=> ref_active);
   assert_line0_reset_R5: assert property (@(posedge clk) disable iff (rst)
      ce && hpos == HPOS_W'(RST_POS) && line_num == '0 |=> row_addr == '0);
   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
      ce && !halt && !ref_active && line_num != '0 && hpos == HPOS_W'(RST_POS)
         && $past(ce) && $past(hpos) == HPOS_W'(RST_POS - 1) && !$past(halt)
      |=> $stable(row_addr));
   assert_sclk_fall_R3: assert property (@(posedge clk) disable iff (rst)
      ce && !halt && hpos == HPOS_W'(SCLK_END_POS) |=> !single_clk_req || halt);

endmodule

// File: tb/raster_refresh_seq_bench.sv
`timescale 1ns/1ps
module raster_refresh_seq_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ce = 1'b0;
   logic [8:0] hpos = '0;
   logic [8:0] line_num = '0;
   logic       halt = 1'b0;
   logic       inhibit_set = 1'b0;
   logic [7:0] row_addr;
   logic       ref_active;
   logic       single_clk_req;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   raster_refresh_seq u_raster_refresh_seq (
      .clk(clk), .rst(rst), .ce(ce), .hpos(hpos), .line_num(line_num),
      .halt(halt), .inhibit_set(inhibit_set), .row_addr(row_addr),
      .ref_active(ref_active), .single_clk_req(single_clk_req)
   );

   task automatic check(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one clock-enable strobe at position h, sampled 1 ns after the edge
   task automatic strb(int h);
      ce = 1'b1;
      hpos = 9'(h);
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check("R1 row", row_addr, 0);
      check("R1 active", ref_active, 0);
      check("R1 sclk", single_clk_req, 0);
      rst = 1'b0;
   endtask

   task automatic t_normal_line();
      line_num = 9'd5;
      for (int h = 290; h <= 350; h++) begin
         strb(h);
         if (h == 296) begin
            check("R3 sclk rise", single_clk_req, 1);
            check("R2 no count at set", ref_active, 0);
         end
         if (h == 297) begin
            check("R2 first step row", row_addr, 1);
            check("R10 active", ref_active, 1);
         end
         if (h == 336) check("R2 last step row", row_addr, 40);
         if (h == 337) begin
            check("R2 closed", ref_active, 0);
            check("R2 row held", row_addr, 40);
         end
         if (h == 343) check("R3 sclk still", single_clk_req, 1);
         if (h == 344) check("R3 sclk fall", single_clk_req, 0);
      end
      for (int h = 351; h <= 440; h++) begin
         strb(h);
         if (h == 431) check("R6 no reset idle line", row_addr, 40);
      end
      line_num = 9'd0;
      strb(431);
      check("R5 line0 reset", row_addr, 0);
      check("R5 active low", ref_active, 0);
   endtask

   task automatic t_skip_clear();
      line_num = 9'd7;
      for (int h = 290; h <= 330; h++) strb(h);
      check("R2 partial count", row_addr, 34);
      for (int h = 340; h <= 430; h++) begin
         strb(h);
         if (h == 345) begin
            check("R3 sclk low window open", single_clk_req, 0);
            check("R3 still counting", ref_active, 1);
         end
      end
      check("R2 overrun count", row_addr, 125);
      strb(431);
      check("R6 reset with window open", row_addr, 0);
      check("R5 reset wins", ref_active, 0);
      strb(432);
      check("R6 count after reset", row_addr, 1);
      for (int h = 433; h <= 435; h++) strb(h);
      strb(336);
      check("R2 clear strobe counts", row_addr, 5);
      strb(337);
      check("R2 closed late", ref_active, 0);
      check("R2 held late", row_addr, 5);
   endtask

   task automatic t_halt_wrap();
      line_num = 9'd3;
      ce = 1'b0;
      halt = 1'b1;
      #1;
      check("R7 sclk forced", single_clk_req, 1);
      strb(100);
      check("R7 halt step", row_addr, 6);
      check("R7 halt active", ref_active, 1);
      for (int i = 0; i < 249; i++) strb(100);
      check("R4 at top", row_addr, 255);
      strb(100);
      check("R4 wrap", row_addr, 0);
      for (int i = 0; i < 5; i++) strb(100);
      strb(431);
      check("R7 halt reset", row_addr, 0);
      check("R7 halt reset active", ref_active, 0);
      strb(100);
      check("R7 after reset", row_addr, 1);
   endtask

   task automatic t_no_ce();
      ce = 1'b0;
      hpos = 9'd100;
      repeat (4) @(posedge clk);
      #1;
      check("R8 halt no ce row", row_addr, 1);
      halt = 1'b0;
      hpos = 9'd296;
      repeat (3) @(posedge clk);
      #1;
      check("R8 no set without ce", single_clk_req, 0);
      check("R8 active held", ref_active, 1);
      hpos = 9'd431;
      line_num = 9'd0;
      repeat (2) @(posedge clk);
      #1;
      check("R8 no reset without ce", row_addr, 1);
   endtask

   task automatic t_inhibit();
      int bad_act = 0;
      int bad_row = 0;
      inhibit_set = 1'b1;
      line_num = 9'd9;
      for (int h = 290; h <= 350; h++) begin
         strb(h);
         if (ref_active) bad_act++;
         if (row_addr != 8'd1) bad_row++;
         if (h == 300) check("R9 sclk unaffected", single_clk_req, 1);
      end
      check("R9 no active pulses", bad_act, 0);
      check("R9 row steady", bad_row, 0);
      check("R9 row value", row_addr, 1);
      inhibit_set = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_normal_line();
      t_skip_clear();
      t_halt_wrap();
      t_no_ce();
      t_inhibit();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule